// File: doc/BRIEF.md
# Fibonacci Bus Code Validity Checker

This block screens a binary word from an n-wire on-chip bus and reports whether the word belongs to the memoryless Fibonacci code. That code is meant for buses where the coupling between adjacent wires costs more than the charge to ground. The checker views each pair of neighbouring wires as one ternary symbol. A pair whose two wires are equal is a zero. A pair that rises from left to right is a plus. A pair that falls from left to right is a minus. The code keeps each polarity to one parity of pair position. As a result, no pair can ever swing straight from plus to minus, which is the most costly transition on such a bus.

The word is screened combinationally, and the result is registered. One cycle after a word is presented, the block gives a flag that marks the word as a codeword. It also gives a mask with one bit per pair position, and each set bit marks a pair that holds the wrong polarity for its position. Typical uses are guarding an encoded bus and checking codeword tables in bulk. The wire count is a parameter.

Top module: `fib_code_checker`

## Requirements
- R1: Bit `bus_word[NUM_WIRES-1]` is the leftmost wire. Pair coordinate k (1 to NUM_WIRES-1) is formed from left wire `bus_word[NUM_WIRES-k]` and right wire `bus_word[NUM_WIRES-k-1]`. Its result appears on `viol_mask[k-1]`.
- R2: A plus pair (left 0, right 1) at an odd coordinate sets its mask bit. At an even coordinate it does not.
- R3: A minus pair (left 1, right 0) at an even coordinate sets its mask bit. At an odd coordinate it does not.
- R4: `code_ok` is 1 exactly when every bit of `viol_mask` is 0.
- R5: The all-zeros word and the all-ones word are both reported as valid.
- R6: For 3 wires, exactly 000, 001, 100 and 101 (the leftmost wire written first) plus 111 are valid. The words 010, 011 and 110 are flagged.
- R7: For 12 wires, exactly 377 of the 4096 words are valid.
- R8: The outputs show the word that was present at the previous rising clock edge, with one cycle of latency.
- R9: A synchronous active-high reset forces `code_ok`=1 and `viol_mask`=0.
- R10: A zero pair (00 or 11) never sets its mask bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_word | input | NUM_WIRES | Bus word to screen, leftmost wire in the MSB |
| code_ok | output | 1 | Registered: word is a Fibonacci codeword |
| viol_mask | output | NUM_WIRES-1 | Registered: bit k-1 set when coordinate k holds a misplaced polarity |

## Verification
The hardest case to reach from the ports is a word whose only fault is a single misplaced symbol deep inside a long run of zero pairs. Random words tend to carry several faults at once, so they hide which coordinate is actually flagged. The stimulus therefore builds words that contain exactly one plus or one minus at each coordinate in turn, and checks both that the mask has exactly one bit set and that it is in the right place. An exhaustive sweep of all 12-wire words, together with a second 3-wire instance, checks the codeword counts.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO  = 2'd0,
        SYM_PLUS  = 2'd1,
        SYM_MINUS = 2'd2
    } pair_sym_e;

    typedef struct packed {
        logic      coord_odd;
        pair_sym_e sym;
    } pair_info_t;

    // Maps a left/right wire pair to its ternary symbol.
    function automatic pair_sym_e sym_of_pair(input logic left_w, input logic right_w);
        if (left_w == right_w)
            return SYM_ZERO;
        else if (!left_w)
            return SYM_PLUS;
        else
            return SYM_MINUS;
    endfunction

    // A polarity is legal only at its own coordinate parity.
    function automatic logic sym_misplaced(input pair_info_t info);
        unique case (info.sym)
            SYM_PLUS:  return info.coord_odd;
            SYM_MINUS: return !info.coord_odd;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fbc_pair_classifier.sv
module fbc_pair_classifier
    import fbc_pkg::*;
#(
    parameter int NUM_WIRES = 12
) (
    input  logic [NUM_WIRES-1:0]             wires,
    output pair_info_t [NUM_WIRES-2:0]       pairs
);
    localparam int NUM_COORDS = NUM_WIRES - 1;

    for (genvar c = 0; c < NUM_COORDS; c++) begin : g_pair
        // coordinate number is c+1; odd when c is even
        localparam logic IS_ODD = ((c % 2) == 0);
        always_comb begin
            pairs[c].coord_odd = IS_ODD;
            pairs[c].sym       = sym_of_pair(wires[NUM_WIRES-1-c], wires[NUM_WIRES-2-c]);
        end
    end
endmodule

// File: rtl/fbc_parity_screen.sv
module fbc_parity_screen
    import fbc_pkg::*;
#(
    parameter int NUM_WIRES = 12
) (
    input  pair_info_t [NUM_WIRES-2:0] pairs,
    output logic [NUM_WIRES-2:0]       bad_mask,
    output logic                       word_ok
);
    localparam int NUM_COORDS = NUM_WIRES - 1;

    for (genvar c = 0; c < NUM_COORDS; c++) begin : g_screen
        always_comb bad_mask[c] = sym_misplaced(pairs[c]);
    end

    always_comb word_ok = ~|bad_mask;
endmodule

// File: rtl/fbc_out_reg.sv
module fbc_out_reg #(
    parameter int MASK_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ok_d,
    input  logic [MASK_W-1:0] mask_d,
    output logic              ok_q,
    output logic [MASK_W-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ok_q   <= 1'b1;
            mask_q <= '0;
        end else begin
            ok_q   <= ok_d;
            mask_q <= mask_d;
        end
    end
endmodule

// File: rtl/fib_code_checker.sv
module fib_code_checker
    import fbc_pkg::*;
#(
    parameter int NUM_WIRES = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WIRES-1:0] bus_word,
    output logic                 code_ok,
    output logic [NUM_WIRES-2:0] viol_mask
);
    localparam int NUM_COORDS = NUM_WIRES - 1;

    pair_info_t [NUM_COORDS-1:0] pairs;
    logic [NUM_COORDS-1:0]       bad_mask;
    logic                        word_ok;

    fbc_pair_classifier #(.NUM_WIRES(NUM_WIRES)) u_classify (
        .wires (bus_word),
        .pairs (pairs)
    );

    fbc_parity_screen #(.NUM_WIRES(NUM_WIRES)) u_screen (
        .pairs    (pairs),
        .bad_mask (bad_mask),
        .word_ok  (word_ok)
    );

    fbc_out_reg #(.MASK_W(NUM_COORDS)) u_oreg (
        .clk    (clk),
        .rst    (rst),
        .ok_d   (word_ok),
        .mask_d (bad_mask),
        .ok_q   (code_ok),
        .mask_q (viol_mask)
    );

    // R9: reset state
    p_reset_state_r9: assert property (@(posedge clk)
        rst |=> (code_ok && viol_mask == '0));

    // R4: flag and mask agree
    p_flag_matches_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (code_ok == (viol_mask == '0)));

    // R5: uniform words are codewords
    p_uniform_valid_r5: assert property (@(posedge clk) disable iff (rst)
        ((bus_word == '0) || (bus_word == '1)) |=> code_ok);

    for (genvar c = 0; c < NUM_COORDS; c++) begin : g_chk
        if ((c % 2) == 0) begin : g_odd
            // R2: plus at odd coordinate flagged
            p_plus_odd_r2: assert property (@(posedge clk) disable iff (rst)
                (!bus_word[NUM_WIRES-1-c] && bus_word[NUM_WIRES-2-c]) |=> viol_mask[c]);
            // R3: minus at odd coordinate allowed
            p_minus_odd_r3: assert property (@(posedge clk) disable iff (rst)
                (bus_word[NUM_WIRES-1-c] && !bus_word[NUM_WIRES-2-c]) |=> !viol_mask[c]);
        end else begin : g_even
            // R3: minus at even coordinate flagged
            p_minus_even_r3: assert property (@(posedge clk) disable iff (rst)
                (bus_word[NUM_WIRES-1-c] && !bus_word[NUM_WIRES-2-c]) |=> viol_mask[c]);
            // R2: plus at even coordinate allowed
            p_plus_even_r2: assert property (@(posedge clk) disable iff (rst)
                (!bus_word[NUM_WIRES-1-c] && bus_word[NUM_WIRES-2-c]) |=> !viol_mask[c]);
        end
        // R10: zero pairs never flagged
        p_zero_clean_r10: assert property (@(posedge clk) disable iff (rst)
            (bus_word[NUM_WIRES-1-c] == bus_word[NUM_WIRES-2-c]) |=> !viol_mask[c]);
    end
endmodule

// File: tb/fib_code_checker_tb_top.sv
module fib_code_checker_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  NW   = 12;
    localparam int  NC   = NW - 1;
    localparam int  NW3  = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NW-1:0]  word = '0;
    logic           ok;
    logic [NC-1:0]  mask;
    logic [NW3-1:0] word3 = '0;
    logic           ok3;
    logic [NW3-2:0] mask3;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fib_code_checker #(.NUM_WIRES(NW)) dut_i (
        .clk(clk), .rst(rst), .bus_word(word), .code_ok(ok), .viol_mask(mask));

    fib_code_checker #(.NUM_WIRES(NW3)) dut3_i (
        .clk(clk), .rst(rst), .bus_word(word3), .code_ok(ok3), .viol_mask(mask3));

    // Reference mask from the requirement text: coord k uses w[NW-k], w[NW-k-1]
    function automatic logic [NC-1:0] ref_mask(input logic [NW-1:0] w);
        logic [NC-1:0] m = '0;
        for (int k = 1; k <= NC; k++) begin
            logic l, r;
            l = w[NW-k];
            r = w[NW-k-1];
            if (!l && r && (k % 2 == 1)) m[k-1] = 1'b1;
            if (l && !r && (k % 2 == 0)) m[k-1] = 1'b1;
        end
        return m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            finish_run();
        end
    end

    // drive at negedge; result registered at next posedge; sample at following negedge
    task automatic apply12(input logic [NW-1:0] w);
        @(negedge clk);
        word = w;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        word = 12'b010101010101;
        word3 = 3'b010;
        repeat (2) @(negedge clk);
        check("R9 ok", ok, 1);
        check("R9 mask", mask, 0);
        check("R9 ok3", ok3, 1);
        rst = 1'b0;
        @(negedge clk);
        check("R8 after release", mask, ref_mask(12'b010101010101));
    endtask

    task automatic t_uniform();
        apply12('0);
        check("R5 zeros", ok, 1);
        apply12('1);
        check("R5 ones", ok, 1);
        check("R10 ones mask", mask, 0);
    endtask

    task automatic t_three_wire();
        logic [7:0] exp_ok = 8'b1011_0011; // bit i = word i valid: 0,1,4,5,7
        int cnt = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            word3 = 3'(i);
            @(negedge clk);
            check("R6 three wire", ok3, exp_ok[i]);
            if (ok3) cnt++;
        end
        check("R6 count", cnt, 5);
    endtask

    task automatic t_single_symbol();
        for (int k = 1; k <= NC; k++) begin
            logic [NW-1:0] w;
            // plus at coord k only: wires 1..k zero, rest one
            w = '0;
            for (int b = 0; b < NW - k; b++) w[b] = 1'b1;
            apply12(w);
            check((k % 2 == 1) ? "R2 plus odd" : "R2 plus even", mask,
                  (k % 2 == 1) ? (32'(1) << (k-1)) : 0);
            check("R1 onehot", $countones(mask) <= 1, 1);
            // minus at coord k only
            apply12(~w);
            check((k % 2 == 0) ? "R3 minus even" : "R3 minus odd", mask,
                  (k % 2 == 0) ? (32'(1) << (k-1)) : 0);
            check("R4 single", ok, (k % 2 == 1));
        end
    endtask

    task automatic t_latency();
        @(negedge clk);
        word = 12'b100000000000; // minus at coord 1: valid
        @(negedge clk);
        word = 12'b011111111111; // plus at coord 1: flagged
        check("R8 holds previous", ok, 1);
        @(negedge clk);
        check("R8 new value", mask, 1);
    endtask

    task automatic t_exhaustive();
        int cnt = 0;
        int bad = 0;
        for (int i = 0; i < (1 << NW); i++) begin
            apply12(NW'(i));
            if (mask !== ref_mask(NW'(i)) || ok !== (ref_mask(NW'(i)) == 0)) begin
                bad++;
                if (bad < 4) check("R1 R4 R10 sweep", {ok, 20'(mask)}, {ref_mask(NW'(i)) == 0, 20'(ref_mask(NW'(i)))});
            end
            if (ok) cnt++;
        end
        check("R1 sweep mismatches", bad, 0);
        check("R7 count", cnt, 377);
    endtask

    task automatic t_mid_reset();
        apply12(12'b010000000000);
        check("R4 flagged", ok, 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9 mid ok", ok, 1);
        check("R9 mid mask", mask, 0);
        rst = 1'b0;
    endtask

    initial begin
        t_reset();
        t_uniform();
        t_three_wire();
        t_single_symbol();
        t_latency();
        t_exhaustive();
        t_mid_reset();
        finish_run();
    end
endmodule